// File: doc/BRIEF.md
# Bit-Sliced Activation-Resident MAC Array

This block is a digital functional model of a compute-in-memory core that keeps a tile of 8-bit unsigned activations resident and multiplies them against a broadcast vector of signed 4-bit weights. The activations are stored as bit planes. Each of 8 column groups corresponds to one tile-width position and holds 8 bit-plane macros. Each macro is 128 channels wide and 16 tile rows deep. A compute request selects one tile row and one weight bit. Every macro ANDs the stored bit of each channel with that channel's weight bit and counts the hits. A compressor in each group then weights the macro counts by bit significance and applies the sign of the weight bit. The 8 group results come out in parallel.

Activations and channels are handled bit-parallel, and the weight is applied one bit per request. Each output is therefore an unshifted partial product, and shift-accumulation across the four weight bits happens downstream. When a layer has fewer than 128 channels, several pixels share a macro row. A segment selector then restricts the sum to one contiguous channel slice. When a layer has more than 128 channels, one pixel spans several rows, and downstream logic adds the per-row results. Because the array is loaded through a row-wide write port, the same storage can take the next layer's outputs while it computes.

Top module: `cim_mac_array`

## Requirements
- R1: While `rst` is high at a clock edge, `res_vld` and `res_data` are cleared to zero.
- R2: A request sampled with `cmp_en` high at clock edge N gives `res_vld` high after edge N+1. `res_vld` is low after any edge N+1 whose edge N saw `cmp_en` low.
- R3: For weight bit k in 0..2, group g returns the sum over the selected channels c of act[g][row][c] times bit k of weight c.
- R4: For weight bit 3 (the two's-complement sign bit), group g returns the negated sum, so it is never positive.
- R5: Bit plane b contributes its stored bit with significance 2^b. The activation value is therefore the sum of plane bits shifted by their plane index, with a maximum magnitude of 128*255 = 32640.
- R6: A write with `wr_en` high stores `wr_data[c]` as the plane `wr_plane` bit of channel c, in row `wr_row` of group `wr_group`. A compute issued in the next cycle sees the new bit. A write to a different row in the same cycle as a compute leaves that compute's result unchanged. A write and a compute to the same row in one cycle are not allowed.
- R7: All 8 groups compute in parallel. Group g drives `res_data[g*16 +: 16]` as a signed 16-bit value.
- R8: Only the row given by `cmp_row` contributes to a result. The other 15 rows have no effect on it.
- R9: Channel segmentation selects which channels contribute. With `seg_log` = s, the 128 channels split into 2^s equal slices. Channel c counts only if c >> (7-s) equals the low s bits of `seg_idx`. With s = 0, all channels count.
- R10: The weight of channel c is `wt_vec[c*4 +: 4]` in two's complement, and `wt_bit` selects which of its bits is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_group | input | 3 | Column group written |
| wr_plane | input | 3 | Activation bit plane written |
| wr_row | input | 4 | Tile row written |
| wr_data | input | 128 | One bit per channel |
| cmp_en | input | 1 | Compute request |
| cmp_row | input | 4 | Tile row read for the compute |
| wt_bit | input | 2 | Weight bit applied this request |
| seg_log | input | 2 | Log2 of the number of channel slices |
| seg_idx | input | 3 | Channel slice selected |
| wt_vec | input | 512 | 128 signed 4-bit weights |
| res_vld | output | 1 | Result valid |
| res_data | output | 128 | 8 signed 16-bit group results |

## Verification
A wrong stored bit, whether in the wrong plane, row or group, shows up as an error of exactly 2^plane in the one group whose channel carries a set weight bit. A full sweep over every row, weight bit and channel slice against arithmetic expectations catches it within the first request that reads that row. A misaligned pipeline shows up as a `res_vld` pulse one cycle early or late, or as results paired with the previous request's weight bits. A sign error shows up only on requests with weight bit 3. Saturation-level patterns, where all activations are 255, expose a truncated accumulator at the extreme magnitude of 32640.

// File: rtl/cim_pkg.sv
package cim_pkg;

  // channel belongs to the selected slice when its upper slog bits match sidx
  function automatic logic seg_hit(input int chan, input int ch_w,
                                   input int slog, input int sidx);
    int hi;
    int want;
    hi   = chan >> (ch_w - slog);
    want = sidx & ((1 << slog) - 1);
    return (hi == want);
  endfunction

  function automatic int acc_width(input int ch, input int bits);
    return $clog2(ch * ((1 << bits) - 1) + 1) + 1;
  endfunction

endpackage

// File: rtl/cim_macro.sv
module cim_macro #(
  parameter int CH    = 128,
  parameter int ROWS  = 16,
  localparam int RW   = $clog2(ROWS),
  localparam int CNTW = $clog2(CH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [CH-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [RW-1:0]   rd_row,
  input  logic [CH-1:0]   wsel,
  output logic [CNTW-1:0] cnt
);

  logic [CH-1:0] mem [ROWS];
  logic [CH-1:0] rd_q;

  // single-port-per-direction storage, read-first, suitable for block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
    if (rd_en) rd_q <= mem[rd_row];
  end

  // local compute units: AND per channel, then population count
  always_comb begin
    cnt = '0;
    for (int c = 0; c < CH; c++) begin
      cnt = cnt + CNTW'(rd_q[c] & wsel[c]);
    end
  end

  // R8: an idle cycle leaves the sensed row untouched
  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/cim_compress.sv
module cim_compress #(
  parameter int BITS  = 8,
  parameter int CNTW  = 8,
  parameter int ACCW  = 16,
  parameter int BOUND = 32640
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   neg,
  input  logic [BITS*CNTW-1:0]   cnt_flat,
  output logic signed [ACCW-1:0] res
);

  localparam int SUMW = ACCW - 1;

  logic [SUMW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int b = 0; b < BITS; b++) begin
      sum = sum + (SUMW'(cnt_flat[b*CNTW +: CNTW]) << b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else if (en) res <= neg ? -$signed({1'b0, sum}) : $signed({1'b0, sum});
  end

  // R4: sign-bit partial products are never positive
  p_sign_bit_nonpos_r4: assert property (@(posedge clk) disable iff (rst)
    (en && neg) |=> (res <= 0));

  // R3: other bits never negative
  p_plain_bit_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !neg) |=> (res >= 0));

  // R5: result stays within the array's arithmetic range
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    en |=> (res <= BOUND && res >= -BOUND));

endmodule

// File: rtl/cim_mac_array.sv
module cim_mac_array #(
  parameter int GROUPS  = 8,
  parameter int BITS    = 8,
  parameter int CH      = 128,
  parameter int ROWS    = 16,
  parameter int WBITS   = 4,
  parameter int MAX_SEG = 3,
  localparam int GW     = $clog2(GROUPS),
  localparam int PW     = $clog2(BITS),
  localparam int RW     = $clog2(ROWS),
  localparam int KW     = $clog2(WBITS),
  localparam int SLW    = $clog2(MAX_SEG + 1),
  localparam int SIW    = MAX_SEG,
  localparam int CHW    = $clog2(CH),
  localparam int CNTW   = $clog2(CH + 1),
  localparam int ACCW   = cim_pkg::acc_width(CH, BITS),
  localparam int BOUND  = CH * ((1 << BITS) - 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [GW-1:0]          wr_group,
  input  logic [PW-1:0]          wr_plane,
  input  logic [RW-1:0]          wr_row,
  input  logic [CH-1:0]          wr_data,
  input  logic                   cmp_en,
  input  logic [RW-1:0]          cmp_row,
  input  logic [KW-1:0]          wt_bit,
  input  logic [SLW-1:0]         seg_log,
  input  logic [SIW-1:0]         seg_idx,
  input  logic [CH*WBITS-1:0]    wt_vec,
  output logic                   res_vld,
  output logic [GROUPS*ACCW-1:0] res_data
);

  // stage 1: weight bits of the selected slice, aligned with the row read
  logic [CH-1:0] wsel_d;
  logic [CH-1:0] wsel_q;
  logic          s1_vld;
  logic          s1_neg;

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      wsel_d[c] = wt_vec[c*WBITS + int'(wt_bit)] &
                  cim_pkg::seg_hit(c, CHW, int'(seg_log), int'(seg_idx));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_neg <= 1'b0;
      wsel_q <= '0;
    end else begin
      s1_vld <= cmp_en;
      if (cmp_en) begin
        s1_neg <= (int'(wt_bit) == WBITS - 1);
        wsel_q <= wsel_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) res_vld <= 1'b0;
    else     res_vld <= s1_vld;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [BITS*CNTW-1:0] cnts;

    for (genvar b = 0; b < BITS; b++) begin : g_plane
      logic we;
      assign we = wr_en && (int'(wr_group) == g) && (int'(wr_plane) == b);

      cim_macro #(.CH(CH), .ROWS(ROWS)) u_macro (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (we),
        .wr_row (wr_row),
        .wr_data(wr_data),
        .rd_en  (cmp_en),
        .rd_row (cmp_row),
        .wsel   (wsel_q),
        .cnt    (cnts[b*CNTW +: CNTW])
      );
    end

    logic signed [ACCW-1:0] gres;

    cim_compress #(.BITS(BITS), .CNTW(CNTW), .ACCW(ACCW), .BOUND(BOUND)) u_comp (
      .clk     (clk),
      .rst     (rst),
      .en      (s1_vld),
      .neg     (s1_neg),
      .cnt_flat(cnts),
      .res     (gres)
    );

    assign res_data[g*ACCW +: ACCW] = gres;
  end

  // R6: a row may not be written and computed in the same cycle
  p_no_row_clash_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cmp_en && (wr_row == cmp_row)));

  // R2: two-cycle request-to-result latency
  p_vld_latency_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_en |=> ##1 res_vld);

  p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> ##1 !res_vld);

endmodule

// File: tb/cim_mac_array_test.sv
`timescale 1ns/1ps
module cim_mac_array_test;

  localparam int G = 8, B = 8, C = 128, R = 16, WB = 4, AW = 16, CW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_group = '0;
  logic [2:0]    wr_plane = '0;
  logic [3:0]    wr_row = '0;
  logic [C-1:0]  wr_data = '0;
  logic          cmp_en = 1'b0;
  logic [3:0]    cmp_row = '0;
  logic [1:0]    wt_bit = '0;
  logic [1:0]    seg_log = '0;
  logic [2:0]    seg_idx = '0;
  logic [C*WB-1:0] wt_vec = '0;
  logic          res_vld;
  logic [G*AW-1:0] res_data;

  cim_mac_array uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_group(wr_group),
    .wr_plane(wr_plane), .wr_row(wr_row), .wr_data(wr_data),
    .cmp_en(cmp_en), .cmp_row(cmp_row), .wt_bit(wt_bit),
    .seg_log(seg_log), .seg_idx(seg_idx), .wt_vec(wt_vec),
    .res_vld(res_vld), .res_data(res_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] act [G][R][C];
  logic [3:0] w [C];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=finish", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  function automatic int expect_val(int g, int r, int k, int sl, int si);
    int s = 0;
    for (int c = 0; c < C; c++) begin
      if ((c >> (CW - sl)) == (si & ((1 << sl) - 1)) && w[c][k])
        s += act[g][r][c];
    end
    return (k == WB - 1) ? -s : s;
  endfunction

  // one write cycle; called at a negedge, returns at the next negedge
  task automatic wr(input int g, input int b, input int r, input logic [C-1:0] d);
    wr_en = 1; wr_group = 3'(g); wr_plane = 3'(b); wr_row = 4'(r); wr_data = d;
    for (int c = 0; c < C; c++) act[g][r][c][b] = d[c];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_w_random();
    for (int c = 0; c < C; c++) begin
      w[c] = 4'($urandom);
      wt_vec[c*WB +: WB] = w[c];
    end
  endtask

  task automatic set_w_all(input logic [3:0] v);
    for (int c = 0; c < C; c++) begin
      w[c] = v;
      wt_vec[c*WB +: WB] = v;
    end
  endtask

  task automatic issue(input int r, input int k, input int sl, input int si);
    cmp_en = 1; cmp_row = 4'(r); wt_bit = 2'(k); seg_log = 2'(sl); seg_idx = 3'(si);
  endtask

  // compute with results checked two edges later
  task automatic compute(input string tag, input int r, input int k,
                         input int sl, input int si);
    int e [G];
    for (int g = 0; g < G; g++) e[g] = expect_val(g, r, k, sl, si);
    issue(r, k, sl, si);
    @(negedge clk);
    cmp_en = 0;
    @(negedge clk);
    chk({tag, " R2 vld"}, int'(res_vld), 1);
    for (int g = 0; g < G; g++)
      chk({tag, " R7 group"}, int'($signed(res_data[g*AW +: AW])), e[g]);
  endtask

  initial begin
    for (int g = 0; g < G; g++)
      for (int r = 0; r < R; r++)
        for (int c = 0; c < C; c++) act[g][r][c] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 vld", int'(res_vld), 0);
    chk("R1 data", int'(res_data == '0), 1);
    rst = 0;
    @(negedge clk);

    // load every plane of every row of every group with random bits (R5, R6)
    for (int g = 0; g < G; g++)
      for (int b = 0; b < B; b++)
        for (int r = 0; r < R; r++)
          wr(g, b, r, {$urandom, $urandom, $urandom, $urandom});

    // R2: idle array produces no valid
    chk("R2 idle", int'(res_vld), 0);

    // sweep rows, weight bits and channel slices (R3, R4, R8, R9, R10)
    for (int r = 0; r < R; r++)
      for (int k = 0; k < WB; k++)
        for (int sl = 0; sl <= 3; sl++)
          for (int si = 0; si < (1 << sl); si++) begin
            set_w_random();
            if (sl != 0)          compute("R9 slice R10", r, k, sl, si);
            else if (k == WB - 1) compute("R4 sign R8 R10", r, k, sl, si);
            else                  compute("R3 plain R8 R10", r, k, sl, si);
          end

    // R5: a lone top plane weighs 128 per channel
    for (int b = 0; b < B; b++) wr(1, b, 4, (b == 7) ? {C{1'b1}} : '0);
    set_w_all(4'h1);
    compute("R5 top plane", 4, 0, 0, 0);

    // R5: extreme magnitude with all activations at 255 and all weights -1
    for (int b = 0; b < B; b++) wr(2, b, 15, {C{1'b1}});
    set_w_all(4'hF);
    compute("R5 max neg R4", 15, 3, 0, 0);
    compute("R5 max pos R3", 15, 0, 0, 0);

    // R6/R8: write another row during a compute; result follows old state
    begin
      int e0;
      logic [C-1:0] inv;
      set_w_random();
      for (int c = 0; c < C; c++) inv[c] = ~act[0][6][c][0];
      e0 = expect_val(0, 5, 1, 0, 0);
      issue(5, 1, 0, 0);
      wr_en = 1; wr_group = 0; wr_plane = 0; wr_row = 6; wr_data = inv;
      @(negedge clk);
      cmp_en = 0; wr_en = 0;
      for (int c = 0; c < C; c++) act[0][6][c][0] = inv[c];
      @(negedge clk);
      chk("R6 concurrent vld", int'(res_vld), 1);
      chk("R6 concurrent R8", int'($signed(res_data[0 +: AW])), e0);
      // new data visible right after the write
      compute("R6 after write", 6, 1, 0, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule